// File: doc/BRIEF.md
# External-Memory Peripheral Interrupt Aggregator

This block collects the interrupt sources of an external-memory style peripheral and presents them as one interrupt line. It has five sources: a sticky error bit, a read-FIFO level source, a write-FIFO free-space source, and two DMA completion bits. A raw status word holds the five source bits. A mask register selects which of them reach the interrupt. A masked status word shows the AND of the two.

The error source merges three causes, and each cause has its own enable or arming. A full write FIFO counts only when its enable is set. A stalled read counts only when its enable is set. A bus-wait timeout fires when a pending transaction waits for ready longer than a programmed limit. A separate cause register records which cause fired. Software clears a cause, or a DMA completion bit, by writing 1 to its bit in that register.

The FIFO and DMA engines sit outside the block. They drive level and pulse inputs, and software uses a small word-addressed register port. The reads are combinational from the current register state. A write takes effect at the clock edge.

Top module: `xmem_irq_ctrl`

## Requirements
- R1: After reset, every status, cause, mask, control and wait-limit register reads zero and `irq` is low.
- R2: The masked status word (address 2) equals the raw status word (address 0) ANDed with the mask (address 1, bits 4:0). Bits 31:5 of all status words read zero. `irq` is high exactly when the masked word is nonzero. The raw bit positions are: 0 error, 1 read-FIFO, 2 write-FIFO, 3 DMA read done, 4 DMA write done.
- R3: A write to address 2 (masked status) or address 0 (raw status) changes no register state.
- R4: While `wf_full` is high and control bit 0 (write-full enable) is set, cause bit 0 (address 3) becomes set on the next edge. While that enable is clear, `wf_full` has no effect.
- R5: While `rd_stall` is high and control bit 1 (read-stall enable) is set, cause bit 1 becomes set on the next edge. While that enable is clear, `rd_stall` has no effect.
- R6: With a nonzero wait limit L (address 5, bits 15:0), cause bit 2 becomes set once `bus_busy` high with `bus_ready` low has been sampled on L+1 consecutive edges. The counter restarts when that condition drops. The cause fires at most once per stall. A limit of zero disables the timeout.
- R7: Raw bit 0 is the OR of the three cause bits. Writing 1 to a cause bit (address 3, bits 2:0) clears only that bit. Writing 0 leaves it unchanged.
- R8: A one-cycle `dma_rd_done` or `dma_wr_done` pulse sets raw bit 3 or raw bit 4. The bit stays set until a write of 1 to address 3 bit 3 or bit 4 clears it. Address 3 reads those two bits back in positions 4:3.
- R9: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: Raw bit 1 follows, one edge later, the condition that the read trigger (control bits 15:8) is nonzero and `rf_level` is at least that trigger. It is not sticky.
- R11: Raw bit 2 follows, one edge later, the condition that the write trigger (control bits 23:16) is nonzero and `wf_free` is at most that trigger. It is not sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address (0 raw, 1 mask, 2 masked, 3 cause/clear, 4 control, 5 wait limit) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wf_full | input | 1 | Write FIFO full (level) |
| rd_stall | input | 1 | Read stalled (level) |
| bus_busy | input | 1 | A bus transaction is pending |
| bus_ready | input | 1 | External ready for the pending transaction |
| rf_level | input | 8 | Read FIFO fill level |
| wf_free | input | 8 | Write FIFO free entries |
| dma_rd_done | input | 1 | DMA read completion pulse |
| dma_wr_done | input | 1 | DMA write completion pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench looks first at the timeout boundary. A stall of exactly L sampled cycles must leave the cause clear, and L+1 must set it. An off-by-one counter would flag early or late. It also clears the timeout cause while the same stall continues, so a counter that fails to saturate would set the cause again. Set-versus-clear collisions on both the DMA bits and the error causes would show a wrong priority as a bit that stays clear. Writes to the read-only status words, a zero trigger level and a zero wait limit each target a design that would let a disabled path change state. Clearing one of two active causes catches a clear that wipes the whole error bit.

// File: rtl/xmem_irq_pkg.sv
package xmem_irq_pkg;
  localparam int NSRC = 5;
  localparam int SRC_ERR = 0;
  localparam int SRC_RDF = 1;
  localparam int SRC_WRF = 2;
  localparam int SRC_DRD = 3;
  localparam int SRC_DWR = 4;

  localparam int NCAUSE   = 3;
  localparam int CZ_WFULL = 0;
  localparam int CZ_RSTALL = 1;
  localparam int CZ_TMO   = 2;

  localparam int A_RAW    = 0;
  localparam int A_MASK   = 1;
  localparam int A_MASKED = 2;
  localparam int A_CAUSE  = 3;
  localparam int A_CTRL   = 4;
  localparam int A_WAIT   = 5;

  localparam int RT_LSB = 8;

  // Read source: fill level has reached a nonzero trigger.
  function automatic logic rd_trig_hit(input int unsigned lvl, input int unsigned trig);
    return (trig != 0) && (lvl >= trig);
  endfunction

  // Write source: free space has dropped to a nonzero trigger or below.
  function automatic logic wr_trig_hit(input int unsigned free_n, input int unsigned trig);
    return (trig != 0) && (free_n <= trig);
  endfunction

  // Sticky bit with write-1 clear; a set in the same cycle wins.
  function automatic logic w1c_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/xmi_sticky_bank.sv
module xmi_sticky_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  import xmem_irq_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= w1c_next(bit_q, set[g], clr[g]);
    end
    assign q[g] = bit_q;
  end
endmodule

// File: rtl/xmi_wait_timer.sv
module xmi_wait_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] limit,
  input  logic              busy,
  input  logic              ready,
  output logic              tmo_pulse
);
  logic [WAIT_W-1:0] cnt_q;
  logic              fired_q;
  logic              stall;
  logic              armed;

  assign stall     = busy & ~ready;
  assign armed     = |limit;
  assign tmo_pulse = stall & armed & ~fired_q & (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (!stall || !armed) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (tmo_pulse) begin
      fired_q <= 1'b1;
    end else if (!fired_q && (cnt_q < limit)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/xmi_regfile.sv
module xmi_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int LVL_W  = 8,
  parameter int WAIT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [xmem_irq_pkg::NSRC-1:0] mask_q,
  output logic                          wfull_en,
  output logic                          rstall_en,
  output logic [LVL_W-1:0]              rd_trig,
  output logic [LVL_W-1:0]              wr_trig,
  output logic [WAIT_W-1:0]             wait_lim,
  output logic [xmem_irq_pkg::NCAUSE-1:0] cause_clr,
  output logic [1:0]                    dma_clr
);
  import xmem_irq_pkg::*;

  localparam int WT_LSB = RT_LSB + LVL_W;

  logic wr_mask, wr_ctrl, wr_wait, wr_cause;
  logic unused_wdata;

  assign wr_mask  = reg_we && (reg_addr == ADDR_W'(A_MASK));
  assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_wait  = reg_we && (reg_addr == ADDR_W'(A_WAIT));
  assign wr_cause = reg_we && (reg_addr == ADDR_W'(A_CAUSE));

  assign cause_clr = wr_cause ? reg_wdata[NCAUSE-1:0] : '0;
  assign dma_clr   = wr_cause ? reg_wdata[SRC_DWR:SRC_DRD] : '0;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      wfull_en  <= 1'b0;
      rstall_en <= 1'b0;
      rd_trig   <= '0;
      wr_trig   <= '0;
      wait_lim  <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[NSRC-1:0];
      if (wr_ctrl) begin
        wfull_en  <= reg_wdata[0];
        rstall_en <= reg_wdata[1];
        rd_trig   <= reg_wdata[RT_LSB +: LVL_W];
        wr_trig   <= reg_wdata[WT_LSB +: LVL_W];
      end
      if (wr_wait) wait_lim <= reg_wdata[WAIT_W-1:0];
    end
  end
endmodule

// File: rtl/xmem_irq_ctrl.sv
module xmem_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int LVL_W  = 8,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wf_full,
  input  logic              rd_stall,
  input  logic              bus_busy,
  input  logic              bus_ready,
  input  logic [LVL_W-1:0]  rf_level,
  input  logic [LVL_W-1:0]  wf_free,
  input  logic              dma_rd_done,
  input  logic              dma_wr_done,
  output logic              irq
);
  import xmem_irq_pkg::*;

  localparam int WT_LSB = RT_LSB + LVL_W;

  logic [NSRC-1:0]   mask_q;
  logic              wfull_en, rstall_en;
  logic [LVL_W-1:0]  rd_trig, wr_trig;
  logic [WAIT_W-1:0] wait_lim;
  logic [NCAUSE-1:0] cause_clr, cause_set, cause_q;
  logic [1:0]        dma_clr, dma_set, dma_q;
  logic              wfull_set, rstall_set, tmo_pulse;
  logic              rf_hit_q, wf_hit_q;
  logic [NSRC-1:0]   raw, masked;
  logic [DATA_W-1:0] ctrl_word;

  xmi_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .WAIT_W(WAIT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mask_q(mask_q), .wfull_en(wfull_en), .rstall_en(rstall_en),
    .rd_trig(rd_trig), .wr_trig(wr_trig), .wait_lim(wait_lim),
    .cause_clr(cause_clr), .dma_clr(dma_clr)
  );

  xmi_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .limit(wait_lim),
    .busy(bus_busy), .ready(bus_ready), .tmo_pulse(tmo_pulse)
  );

  assign wfull_set  = wf_full & wfull_en;
  assign rstall_set = rd_stall & rstall_en;

  always_comb begin
    cause_set            = '0;
    cause_set[CZ_WFULL]  = wfull_set;
    cause_set[CZ_RSTALL] = rstall_set;
    cause_set[CZ_TMO]    = tmo_pulse;
  end

  assign dma_set = {dma_wr_done, dma_rd_done};

  xmi_sticky_bank #(.N(NCAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n), .set(cause_set), .clr(cause_clr), .q(cause_q)
  );

  xmi_sticky_bank #(.N(2)) u_dma (
    .clk(clk), .rst_n(rst_n), .set(dma_set), .clr(dma_clr), .q(dma_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_hit_q <= 1'b0;
      wf_hit_q <= 1'b0;
    end else begin
      rf_hit_q <= rd_trig_hit(32'(rf_level), 32'(rd_trig));
      wf_hit_q <= wr_trig_hit(32'(wf_free), 32'(wr_trig));
    end
  end

  always_comb begin
    raw          = '0;
    raw[SRC_ERR] = |cause_q;
    raw[SRC_RDF] = rf_hit_q;
    raw[SRC_WRF] = wf_hit_q;
    raw[SRC_DRD] = dma_q[0];
    raw[SRC_DWR] = dma_q[1];
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[0]                = wfull_en;
    ctrl_word[1]                = rstall_en;
    ctrl_word[RT_LSB +: LVL_W]  = rd_trig;
    ctrl_word[WT_LSB +: LVL_W]  = wr_trig;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_RAW):    reg_rdata = DATA_W'(raw);
      ADDR_W'(A_MASK):   reg_rdata = DATA_W'(mask_q);
      ADDR_W'(A_MASKED): reg_rdata = DATA_W'(masked);
      ADDR_W'(A_CAUSE):  reg_rdata = DATA_W'({dma_q, cause_q});
      ADDR_W'(A_CTRL):   reg_rdata = ctrl_word;
      ADDR_W'(A_WAIT):   reg_rdata = DATA_W'(wait_lim);
      default:           reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xmem_irq_chk.sv
module xmem_irq_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int WAIT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic              wfull_set,
  input logic              tmo_pulse,
  input logic [WAIT_W-1:0] wait_lim,
  input logic [2:0]        cause_q,
  input logic [4:0]        raw,
  input logic [4:0]        mask_q,
  input logic              dma_rd_done
);
  p_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(raw & mask_q));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(2)) |-> (reg_rdata[DATA_W-1:5] == '0));

  p_masked_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(2)) |=> $stable(mask_q));

  p_tmo_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);

  p_tmo_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_lim == '0) |-> !tmo_pulse);

  p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(3) && reg_wdata[0] && !wfull_set) |=> !cause_q[0]);

  p_dma_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_done |=> raw[3]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wfull_set |=> cause_q[0]);
endmodule

bind xmem_irq_ctrl xmem_irq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .wfull_set(wfull_set), .tmo_pulse(tmo_pulse), .wait_lim(wait_lim),
  .cause_q(cause_q), .raw(raw), .mask_q(mask_q), .dma_rd_done(dma_rd_done)
);

// File: tb/sim_xmem_irq_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        wf_full = 1'b0, rd_stall = 1'b0, bus_busy = 1'b0, bus_ready = 1'b0;
  logic [7:0]  rf_level = 8'd0, wf_free = 8'd0;
  logic        dma_rd_done = 1'b0, dma_wr_done = 1'b0;
  logic        irq;

  always #2 clk = ~clk;

  xmem_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wf_full(wf_full),
    .rd_stall(rd_stall), .bus_busy(bus_busy), .bus_ready(bus_ready),
    .rf_level(rf_level), .wf_free(wf_free), .dma_rd_done(dma_rd_done),
    .dma_wr_done(dma_wr_done), .irq(irq)
  );

  // Behavioural reference state
  int unsigned m_mask = 0, m_cause = 0, m_dma = 0, m_rf = 0, m_wf = 0;
  int unsigned m_enw = 0, m_enr = 0, m_rt = 0, m_wt = 0, m_lim = 0;
  int unsigned m_stallcnt = 0, m_done = 0;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int unsigned view = 0;
  bit finished = 0;

  always @(posedge clk) begin : model
    int unsigned setc, clrc, setd, clrd;
    if (!rst_n) begin
      m_mask = 0; m_cause = 0; m_dma = 0; m_rf = 0; m_wf = 0;
      m_enw = 0; m_enr = 0; m_rt = 0; m_wt = 0; m_lim = 0;
      m_stallcnt = 0; m_done = 0;
    end else begin
      setc = 0; clrc = 0; setd = 0; clrd = 0;
      if (wf_full && m_enw != 0) setc += 1;
      if (rd_stall && m_enr != 0) setc += 2;
      if (bus_busy && !bus_ready && m_lim != 0) begin
        m_stallcnt++;
        if (m_stallcnt == m_lim + 1 && m_done == 0) begin
          setc += 4;
          m_done = 1;
        end
      end else begin
        m_stallcnt = 0;
        m_done = 0;
      end
      if (dma_rd_done) setd += 1;
      if (dma_wr_done) setd += 2;
      if (reg_we && reg_addr == 3) begin
        clrc = reg_wdata & 7;
        clrd = (reg_wdata >> 3) & 3;
      end
      m_cause = (m_cause & ~clrc) | setc;
      m_dma   = (m_dma & ~clrd) | setd;
      m_rf = (m_rt > 0 && rf_level >= m_rt) ? 1 : 0;
      m_wf = (m_wt > 0 && wf_free <= m_wt) ? 1 : 0;
      if (reg_we) begin
        if (reg_addr == 1) m_mask = reg_wdata % 32;
        if (reg_addr == 4) begin
          m_enw = reg_wdata[0];
          m_enr = reg_wdata[1];
          m_rt  = reg_wdata[15:8];
          m_wt  = reg_wdata[23:16];
        end
        if (reg_addr == 5) m_lim = reg_wdata % 65536;
      end
    end
  end

  function automatic int unsigned exp_raw();
    return m_dma * 8 + m_wf * 4 + m_rf * 2 + ((m_cause != 0) ? 1 : 0);
  endfunction

  function automatic int unsigned exp_read(input int unsigned a);
    case (a)
      0: return exp_raw();
      1: return m_mask;
      2: return exp_raw() & m_mask;
      3: return m_dma * 8 + m_cause;
      4: return m_wt * 65536 + m_rt * 256 + m_enr * 2 + m_enw;
      5: return m_lim;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin : compare
    int unsigned er;
    bit ei;
    if (!finished) begin
      er = exp_read(reg_addr);
      ei = ((exp_raw() & m_mask) != 0);
      n_cmp++;
      if (reg_rdata !== er || irq !== ei) begin
        n_bad++;
        $display("FAIL %s addr=%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                 tag, reg_addr, reg_rdata, irq, er, ei);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic look(input int unsigned a);
    view = a;
    reg_addr = a[2:0];
  endtask

  task automatic wr(input int unsigned a, input int unsigned d);
    reg_we = 1'b1;
    reg_addr = a[2:0];
    reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
    reg_addr = view[2:0];
  endtask

  task automatic sweep();
    for (int a = 0; a < 8; a++) begin
      look(a);
      tick(1);
    end
  endtask

  task automatic done();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      done();
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    tick(3);
    sweep();
    rst_n = 1'b1;
    sweep();

    // R8: DMA completion sets, masked off at first
    tag = "R8";
    look(0);
    dma_rd_done = 1'b1; tick(1); dma_rd_done = 1'b0;
    tick(2);
    dma_wr_done = 1'b1; tick(1); dma_wr_done = 1'b0;
    look(3); tick(2);

    // R2: mask and masked word, irq
    tag = "R2";
    look(2);
    wr(1, 32'hFFFF_FFF0); tick(2);
    wr(1, 32'h0000_0008); tick(2);
    wr(1, 32'h0000_001F); tick(2);
    look(1); tick(1);

    // R3: writes to status words ignored
    tag = "R3";
    look(2);
    wr(2, 32'hFFFF_FFFF); tick(1);
    wr(0, 32'h0000_0000); tick(1);
    look(0); tick(1);
    look(1); tick(1);

    // R8: write-1 clears each DMA bit separately
    tag = "R8";
    look(0);
    wr(3, 32'h0000_0008); tick(2);
    wr(3, 32'h0000_0000); tick(1);
    wr(3, 32'h0000_0010); tick(2);

    // R9: DMA set and clear in the same cycle
    tag = "R9";
    dma_rd_done = 1'b1;
    wr(3, 32'h0000_0008);
    dma_rd_done = 1'b0;
    tick(2);
    wr(3, 32'h0000_0008); tick(2);

    // R4: write-full cause gated by enable
    tag = "R4";
    look(3);
    wf_full = 1'b1; tick(3);
    wr(4, 32'h0000_0001); tick(2);
    wf_full = 1'b0; tick(1);

    // R7: write 0 keeps cause, write 1 clears
    tag = "R7";
    wr(3, 32'h0000_0000); tick(1);
    look(0); tick(1);
    look(3);
    wr(3, 32'h0000_0001); tick(2);

    // R5: read-stall cause gated by enable
    tag = "R5";
    wr(4, 32'h0000_0000);
    rd_stall = 1'b1; tick(3);
    wr(4, 32'h0000_0002); tick(2);
    rd_stall = 1'b0;

    // R9: held cause plus clear in the same cycle
    tag = "R9";
    wr(4, 32'h0000_0003);
    wf_full = 1'b1;
    wr(3, 32'h0000_0001); tick(1);
    wf_full = 1'b0;
    tick(1);

    // R7: two causes, clear one, error bit stays
    tag = "R7";
    look(0);
    wr(3, 32'h0000_0001); tick(1);
    look(3); tick(1);
    wr(3, 32'h0000_0002); tick(1);
    look(0); tick(1);

    // R6: timeout boundary, one-per-stall, zero limit
    tag = "R6";
    look(3);
    wr(5, 4);
    bus_busy = 1'b1; bus_ready = 1'b0; tick(4);
    bus_ready = 1'b1; tick(2);
    bus_ready = 1'b0; tick(5);
    tick(2);
    wr(3, 32'h0000_0004); tick(6);
    bus_busy = 1'b0; tick(1);
    bus_busy = 1'b1; tick(8);
    bus_busy = 1'b0;
    wr(3, 32'h0000_0004);
    wr(5, 0);
    bus_busy = 1'b1; tick(20);
    bus_busy = 1'b0;
    wr(5, 1);
    bus_busy = 1'b1; tick(1);
    bus_busy = 1'b0; tick(1);
    bus_busy = 1'b1; tick(3);
    bus_busy = 1'b0;
    look(5); tick(1);
    look(3);
    wr(3, 32'h0000_0007); tick(1);

    // R10: read-FIFO level source
    tag = "R10";
    look(0);
    rf_level = 8'd9; tick(2);
    wr(4, 32'h0000_0400);
    rf_level = 8'd3; tick(2);
    rf_level = 8'd4; tick(2);
    rf_level = 8'd7; tick(1);
    rf_level = 8'd2; tick(2);
    rf_level = 8'd4;
    look(2); tick(2);
    look(4); tick(1);

    // R11: write-FIFO free-space source
    tag = "R11";
    look(0);
    wr(4, 32'h0003_0000);
    wf_free = 8'd5; tick(2);
    wf_free = 8'd3; tick(2);
    wf_free = 8'd0; tick(2);
    wf_free = 8'd4; tick(2);
    wr(4, 32'h0000_0000);
    wf_free = 8'd0; tick(2);
    look(4); tick(1);

    tag = "R1";
    sweep();
    done();
  end
endmodule